// File: doc/BRIEF.md
# Audio clock domain routing selector

This block decides which frame-clock/bit-clock pair feeds each of nine serial input ports. Nine clock pad pairs are present. The lowest three pairs always serve the input side. Each of the upper six pairs can instead be handed to the output side by one direction bit. A pair handed to the output side has its pad output-enable raised, and no input port may use it.

In slave mode, every input port names the pair it wants through its own select field. In master mode the select fields are ignored and port N takes pair N. A port that asks for a pair it cannot use gets clocks held low and raises its error flag. A global budget check adds up the slot counts of the enabled ports and flags any setting that needs more than the channel limit.

Configuration is captured into registers on a write strobe. All outputs are registered, so the clocks seen at a port are the pad levels sampled one cycle earlier. The block works on clocks sampled in the system clock domain; it does no glitch-free switching.

Top module: `aclk_route`

## Requirements
- R1: While `rst` is high at a clock edge, every output and every configuration register is cleared to zero after that edge. Zero configuration means slave mode, all pairs on the input side, all ports disabled, all selects 0 and all slot counts 0.
- R2: Configuration inputs are captured only at an edge where `cfg_we` is 1. At other edges, changes on them have no effect on any output.
- R3: Pairs 0, 1 and 2 can always be used by input ports, whatever `cfg_pad_dir` holds.
- R4: Bit k of `cfg_pad_dir` (k = 0..5) controls pair k+3. A value of 1 sends that pair to the output side and drives `pad_oe[k]` high. A value of 0 keeps it on the input side with `pad_oe[k]` low.
- R5: In slave mode (`cfg_master` = 0), an enabled port p follows pad pair `cfg_dom_sel[4p+3:4p]`, provided that pair is usable.
- R6: In master mode (`cfg_master` = 1), an enabled port p follows pad pair p, and the select fields have no effect.
- R7: An enabled port whose chosen pair is unusable has both clocks held low and `port_err[p]` high. A pair is unusable when it is on the output side or when its select value is 9 to 15.
- R8: A port whose bit in `cfg_port_en` is 0 has both clocks low and its error flag low.
- R9: `ch_overflow` is 1 when the 5-bit slot counts `cfg_slots[5p+4:5p]` of the enabled ports add up to more than 24. A total of exactly 24 does not set it.
- R10: Every output is registered. It reflects the configuration registers and the pad levels present at the previous clock edge, with exactly one cycle of delay from the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pad_dir | input | 6 | Direction of pairs 3..8; 1 means output side |
| cfg_master | input | 1 | 1 selects master mode |
| cfg_port_en | input | 9 | Per-port enable |
| cfg_dom_sel | input | 36 | Per-port 4-bit pair select |
| cfg_slots | input | 45 | Per-port 5-bit slot count |
| pad_lrclk | input | 9 | Frame clocks sampled from the pads |
| pad_bclk | input | 9 | Bit clocks sampled from the pads |
| pad_oe | output | 6 | Pad output-enables for pairs 3..8 |
| port_lrclk | output | 9 | Frame clock delivered to each input port |
| port_bclk | output | 9 | Bit clock delivered to each input port |
| port_err | output | 9 | Per-port unusable-selection flag |
| ch_overflow | output | 1 | Channel budget exceeded |

## Verification
Frame and bit pads are driven with independent random levels, so a port wired to the wrong pair, or with frame and bit clocks swapped, shows a mismatch within a few cycles. One phase drives a simple alternating pattern on the pads to pin down the single cycle of delay. Directed settings separate the fixed pairs, which must stay usable when all direction bits are set, from the assignable pairs, and slave selects from the master-mode bypass. Other settings give out-of-range selects and disabled ports, and slot totals of exactly 24 and of 25. A long random phase with sparse write strobes then checks that configuration changes land only when the strobe is high.

// File: rtl/aclk_route_pkg.sv
package aclk_route_pkg;
  localparam int NUM_DOM   = 9;
  localparam int NUM_FIXED = 3;
  localparam int SEL_W     = 4;
  localparam int SLOT_W    = 5;
  localparam int CH_LIMIT  = 24;
endpackage

// File: rtl/aclk_route_cfg.sv
module aclk_route_cfg #(
  parameter int NUM_DOM   = 9,
  parameter int NUM_ASG   = 6,
  parameter int SEL_W     = 4,
  parameter int SLOT_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [NUM_ASG-1:0]        dir_in,
  input  logic                      master_in,
  input  logic [NUM_DOM-1:0]        en_in,
  input  logic [NUM_DOM*SEL_W-1:0]  sel_in,
  input  logic [NUM_DOM*SLOT_W-1:0] slots_in,
  output logic [NUM_ASG-1:0]        dir_q,
  output logic                      master_q,
  output logic [NUM_DOM-1:0]        en_q,
  output logic [NUM_DOM*SEL_W-1:0]  sel_q,
  output logic [NUM_DOM*SLOT_W-1:0] slots_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '0;
      master_q <= 1'b0;
      en_q     <= '0;
      sel_q    <= '0;
      slots_q  <= '0;
    end else if (we) begin
      dir_q    <= dir_in;
      master_q <= master_in;
      en_q     <= en_in;
      sel_q    <= sel_in;
      slots_q  <= slots_in;
    end
  end
endmodule

// File: rtl/aclk_route_port_mux.sv
module aclk_route_port_mux #(
  parameter int NUM_DOM = 9,
  parameter int SEL_W   = 4,
  parameter int PORT    = 0
) (
  input  logic               master,
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_DOM-1:0] avail,
  input  logic [NUM_DOM-1:0] pad_lr,
  input  logic [NUM_DOM-1:0] pad_bc,
  output logic               lr,
  output logic               bc,
  output logic               err
);
  localparam int EXT = 1 << SEL_W;
  localparam logic [SEL_W-1:0] OWN_DOM = SEL_W'(PORT);

  logic [EXT-1:0]   av_x, lr_x, bc_x;
  logic [SEL_W-1:0] dom;
  logic             ok;

  assign av_x = EXT'(avail);
  assign lr_x = EXT'(pad_lr);
  assign bc_x = EXT'(pad_bc);
  assign dom  = master ? OWN_DOM : sel;
  assign ok   = av_x[dom];
  assign lr   = en & ok & lr_x[dom];
  assign bc   = en & ok & bc_x[dom];
  assign err  = en & ~ok;
endmodule

// File: rtl/aclk_route_budget.sv
module aclk_route_budget #(
  parameter int NUM_DOM  = 9,
  parameter int SLOT_W   = 5,
  parameter int CH_LIMIT = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_DOM-1:0]        en,
  input  logic [NUM_DOM*SLOT_W-1:0] slots,
  output logic                      ovf
);
  localparam int SUM_W = $clog2(NUM_DOM * ((1 << SLOT_W) - 1) + 1);

  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int p = 0; p < NUM_DOM; p++) begin
      if (en[p]) total = total + SUM_W'(slots[p*SLOT_W +: SLOT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else     ovf <= (total > SUM_W'(CH_LIMIT));
  end

  AST_IDLE_NO_OVF: assert property (@(posedge clk) disable iff (rst) $past(en == '0) |-> !ovf); // R9
endmodule

// File: rtl/aclk_route.sv
module aclk_route
  import aclk_route_pkg::*;
#(
  parameter int NUM_DOM   = aclk_route_pkg::NUM_DOM,
  parameter int NUM_FIXED = aclk_route_pkg::NUM_FIXED,
  parameter int SEL_W     = aclk_route_pkg::SEL_W,
  parameter int SLOT_W    = aclk_route_pkg::SLOT_W,
  parameter int CH_LIMIT  = aclk_route_pkg::CH_LIMIT,
  localparam int NUM_ASG  = NUM_DOM - NUM_FIXED
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [NUM_ASG-1:0]        cfg_pad_dir,
  input  logic                      cfg_master,
  input  logic [NUM_DOM-1:0]        cfg_port_en,
  input  logic [NUM_DOM*SEL_W-1:0]  cfg_dom_sel,
  input  logic [NUM_DOM*SLOT_W-1:0] cfg_slots,
  input  logic [NUM_DOM-1:0]        pad_lrclk,
  input  logic [NUM_DOM-1:0]        pad_bclk,
  output logic [NUM_ASG-1:0]        pad_oe,
  output logic [NUM_DOM-1:0]        port_lrclk,
  output logic [NUM_DOM-1:0]        port_bclk,
  output logic [NUM_DOM-1:0]        port_err,
  output logic                      ch_overflow
);
  logic [NUM_ASG-1:0]        dir_q;
  logic                      master_q;
  logic [NUM_DOM-1:0]        en_q;
  logic [NUM_DOM*SEL_W-1:0]  sel_q;
  logic [NUM_DOM*SLOT_W-1:0] slots_q;
  logic [NUM_DOM-1:0]        avail;
  logic [NUM_DOM-1:0]        lr_c, bc_c, err_c;

  aclk_route_cfg #(
    .NUM_DOM(NUM_DOM), .NUM_ASG(NUM_ASG), .SEL_W(SEL_W), .SLOT_W(SLOT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .dir_in(cfg_pad_dir), .master_in(cfg_master), .en_in(cfg_port_en),
    .sel_in(cfg_dom_sel), .slots_in(cfg_slots),
    .dir_q(dir_q), .master_q(master_q), .en_q(en_q),
    .sel_q(sel_q), .slots_q(slots_q)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_avail
    if (d < NUM_FIXED) begin : g_fixed
      assign avail[d] = 1'b1;
    end else begin : g_asg
      assign avail[d] = ~dir_q[d-NUM_FIXED];
    end
  end

  for (genvar p = 0; p < NUM_DOM; p++) begin : g_port
    aclk_route_port_mux #(
      .NUM_DOM(NUM_DOM), .SEL_W(SEL_W), .PORT(p)
    ) u_mux (
      .master(master_q), .en(en_q[p]), .sel(sel_q[p*SEL_W +: SEL_W]),
      .avail(avail), .pad_lr(pad_lrclk), .pad_bc(pad_bclk),
      .lr(lr_c[p]), .bc(bc_c[p]), .err(err_c[p])
    );

    AST_FIXED_USABLE: assert property (@(posedge clk) disable iff (rst)
      $past(!master_q && en_q[p] && (sel_q[p*SEL_W +: SEL_W] < SEL_W'(NUM_FIXED))) |-> !port_err[p]); // R3
    AST_MASTER_OWN: assert property (@(posedge clk) disable iff (rst)
      $past(master_q && en_q[p] && avail[p]) |->
        (port_lrclk[p] == $past(pad_lrclk[p]) && port_bclk[p] == $past(pad_bclk[p]))); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
      port_err[p] |-> (!port_lrclk[p] && !port_bclk[p])); // R7
    AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
      $past(!en_q[p]) |-> (!port_err[p] && !port_lrclk[p] && !port_bclk[p])); // R8
  end

  aclk_route_budget #(
    .NUM_DOM(NUM_DOM), .SLOT_W(SLOT_W), .CH_LIMIT(CH_LIMIT)
  ) u_budget (
    .clk(clk), .rst(rst), .en(en_q), .slots(slots_q), .ovf(ch_overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe     <= '0;
      port_lrclk <= '0;
      port_bclk  <= '0;
      port_err   <= '0;
    end else begin
      pad_oe     <= dir_q;
      port_lrclk <= lr_c;
      port_bclk  <= bc_c;
      port_err   <= err_c;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && port_lrclk == '0 && port_bclk == '0 && port_err == '0 && !ch_overflow)); // R1
  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (rst)
    pad_oe == $past(dir_q)); // R4
endmodule

// File: tb/aclk_route_test.sv
`timescale 1ns/1ps
module aclk_route_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_pad_dir = '0;
  logic        cfg_master = 1'b0;
  logic [8:0]  cfg_port_en = '0;
  logic [35:0] cfg_dom_sel = '0;
  logic [44:0] cfg_slots = '0;
  logic [8:0]  pad_lrclk = '0;
  logic [8:0]  pad_bclk = '0;
  logic [5:0]  pad_oe;
  logic [8:0]  port_lrclk, port_bclk, port_err;
  logic        ch_overflow;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  bit    pad_alt = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  aclk_route uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pad_dir(cfg_pad_dir),
    .cfg_master(cfg_master), .cfg_port_en(cfg_port_en), .cfg_dom_sel(cfg_dom_sel),
    .cfg_slots(cfg_slots), .pad_lrclk(pad_lrclk), .pad_bclk(pad_bclk),
    .pad_oe(pad_oe), .port_lrclk(port_lrclk), .port_bclk(port_bclk),
    .port_err(port_err), .ch_overflow(ch_overflow)
  );

  // Behavioural reference: configuration state plus expected outputs.
  logic [5:0]  m_dir = '0;
  bit          m_master = 1'b0;
  logic [8:0]  m_en = '0;
  int          m_sel[9];
  int          m_slots[9];
  logic [5:0]  e_oe = '0;
  logic [8:0]  e_lr = '0, e_bc = '0, e_err = '0;
  bit          e_ovf = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = '0; m_master = 0; m_en = '0;
      for (int p = 0; p < 9; p++) begin m_sel[p] = 0; m_slots[p] = 0; end
      e_oe = '0; e_lr = '0; e_bc = '0; e_err = '0; e_ovf = 0;
    end else begin
      int total;
      total = 0;
      e_oe = m_dir;
      for (int p = 0; p < 9; p++) begin
        int  d;
        bit  usable;
        d = m_master ? p : m_sel[p];
        usable = (d < 9) && ((d < 3) || !m_dir[(d < 3) ? 0 : d - 3]);
        e_lr[p] = 0; e_bc[p] = 0; e_err[p] = 0;
        if (m_en[p]) begin
          total += m_slots[p];
          if (usable) begin e_lr[p] = pad_lrclk[d]; e_bc[p] = pad_bclk[d]; end
          else e_err[p] = 1;
        end
      end
      e_ovf = total > 24;
      if (cfg_we) begin
        m_dir = cfg_pad_dir; m_master = cfg_master; m_en = cfg_port_en;
        for (int p = 0; p < 9; p++) begin
          m_sel[p] = int'(cfg_dom_sel[4*p +: 4]);
          m_slots[p] = int'(cfg_slots[5*p +: 5]);
        end
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("pad_oe (R4)", 32'(pad_oe), 32'(e_oe));
      check(m_master ? "port clocks (R6)" : "port clocks (R5)", 32'({port_lrclk, port_bclk}), 32'({e_lr, e_bc}));
      check("port_err (R7)", 32'(port_err), 32'(e_err));
      check("ch_overflow (R9)", 32'(ch_overflow), 32'(e_ovf));
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
      if (pad_alt) begin pad_lrclk = ~pad_lrclk; pad_bclk = ~pad_bclk ^ 9'h0AA; end
      else begin pad_lrclk = 9'($urandom); pad_bclk = 9'($urandom); end
    end
  endtask

  task automatic write_cfg(logic [5:0] dir, bit mst, logic [8:0] en,
                           logic [35:0] sel, logic [44:0] slots, bit we);
    @(negedge clk);
    #1;
    cfg_pad_dir = dir; cfg_master = mst; cfg_port_en = en;
    cfg_dom_sel = sel; cfg_slots = slots; cfg_we = we;
    @(negedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [35:0] sel_all(int base, int stride);
    logic [35:0] v;
    for (int p = 0; p < 9; p++) v[4*p +: 4] = 4'((base + stride * p) % 16);
    return v;
  endfunction

  function automatic logic [44:0] slots_of(int a, int b, int rest);
    logic [44:0] v;
    for (int p = 0; p < 9; p++) v[5*p +: 5] = 5'(p == 0 ? a : (p == 1 ? b : rest));
    return v;
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
    step(2);
    #1 rst = 1'b0;
    step(3);
    phase = "R2";  // staged values without strobe must not land
    write_cfg(6'h3F, 1'b1, 9'h1FF, sel_all(1, 1), slots_of(20, 20, 0), 1'b0);
    step(4);
    check("outputs idle without strobe (R2)", 32'({port_err, pad_oe, ch_overflow}), 32'h0);
    phase = "R3";  // fixed pairs survive all-output direction
    write_cfg(6'h3F, 1'b0, 9'h1FF, sel_all(0, 1) & 36'h222_222_210 | 36'h012_012_000, slots_of(1, 1, 1), 1'b1);
    step(20);
    phase = "R4";
    for (int k = 0; k < 6; k++) begin
      write_cfg(6'(1 << k), 1'b0, 9'h1FF, sel_all(3, 1), slots_of(2, 2, 2), 1'b1);
      step(6);
    end
    phase = "R5";
    for (int b = 0; b < 9; b++) begin
      write_cfg(6'h00, 1'b0, 9'h1FF, sel_all(b, 2), slots_of(2, 2, 2), 1'b1);
      step(6);
    end
    phase = "R6";  // selects point elsewhere but are bypassed
    write_cfg(6'h15, 1'b1, 9'h1FF, sel_all(15, 0), slots_of(2, 2, 2), 1'b1);
    step(20);
    phase = "R7";  // out-of-range selects 9..15
    write_cfg(6'h00, 1'b0, 9'h1FF, sel_all(9, 1), slots_of(0, 0, 0), 1'b1);
    step(10);
    phase = "R8";
    write_cfg(6'h2A, 1'b0, 9'h0A5, sel_all(12, 1), slots_of(31, 31, 31), 1'b1);
    step(10);
    phase = "R9";
    write_cfg(6'h00, 1'b0, 9'h003, sel_all(0, 1), slots_of(16, 8, 9), 1'b1);
    step(3);
    check("total 24 flags nothing (R9)", 32'(ch_overflow), 32'h0);
    write_cfg(6'h00, 1'b0, 9'h003, sel_all(0, 1), slots_of(16, 9, 9), 1'b1);
    step(3);
    check("total 25 flags overflow (R9)", 32'(ch_overflow), 32'h1);
    write_cfg(6'h00, 1'b0, 9'h003, sel_all(0, 1), slots_of(16, 16, 0), 1'b1);
    step(3);
    phase = "R10";  // alternating pads expose the one-cycle delay
    write_cfg(6'h00, 1'b0, 9'h1FF, sel_all(0, 1), slots_of(1, 1, 1), 1'b1);
    pad_alt = 1'b1;
    step(20);
    pad_alt = 1'b0;
    phase = "R2";  // random configuration with sparse strobes
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      #1;
      cfg_pad_dir = 6'($urandom); cfg_master = 1'($urandom % 4 == 0);
      cfg_port_en = 9'($urandom);
      for (int p = 0; p < 9; p++) begin
        cfg_dom_sel[4*p +: 4] = 4'($urandom % 11);
        cfg_slots[5*p +: 5] = 5'($urandom % 9);
      end
      cfg_we = ($urandom % 5 == 0);
      pad_lrclk = 9'($urandom); pad_bclk = 9'($urandom);
    end
    @(negedge clk);
    #1 cfg_we = 1'b0;
    step(3);
    phase = "R1";  // reset again mid-run
    rst = 1'b1;
    step(3);
    check("cleared after reset (R1)", 32'({port_lrclk, port_bclk, port_err, pad_oe, ch_overflow}), 32'h0);
    rst = 1'b0;
    step(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule